// File: doc/BRIEF.md
# Proximity Card Downlink Framer

This block serialises a stream of host bytes into the reader-to-card bit sequence of a type A proximity link and codes it as Modified Miller pauses. It is clocked by the system clock. A carrier-rate enable marks each 13.56 MHz carrier cycle, and all bit timing counts those enabled cycles.

The host selects a speed and pulses `start` while it presents the first byte on a valid/ready handshake. The block latches the speed and that byte. It adds the start bit, and it adds a parity bit after each byte, using the rule for the chosen speed. It asks for each following byte while the current byte's parity bit is on the air. The frame ends with a logical zero followed by one silent bit period. A one-clock `done` pulse then marks completion.

The `pause` output is high while the carrier must be switched off, which gives 100 % amplitude keying. CRC, the analog drive and the receive direction are handled elsewhere.

Top module: `pcd_tx_framer`

## Requirements
- R1: While reset is asserted, and right after it, `pause`, `busy`, `done` and `tx_ready` are all 0.
- R2: One bit lasts 128 enabled carrier cycles for speed code 0 (106 kbit/s), 64 for code 1 (212 kbit/s) and 32 for code 2 (424 kbit/s). Code 3 behaves as code 2.
- R3: At speed code 0 the frame opens with a start bit of 1. Each byte is sent least significant bit first and is followed by an odd parity bit (the byte and its parity together hold an odd number of ones).
- R4: At speed codes 1 and 2 the frame opens with a start bit of 0. Every byte carries odd parity except the byte flagged with `tx_last`, which carries even parity.
- R5: A logical 1 is coded as a pause in the second half of its bit. A logical 0 is coded as a pause at the start of its bit, unless the previous bit was 1, in which case it has no pause. The first bit of a frame is treated as following a 0.
- R6: Every pause lasts one quarter of the bit period. An early pause covers cycles 0 to L/4-1 of the bit and a late pause covers cycles L/2 to 3L/4-1, where L is the bit length. `pause` is never high while `busy` is low.
- R7: After the last byte's parity bit, the block sends a logical 0 and then one bit period without any pause. In the clock after that period ends, `done` is high for exactly one cycle and `busy` is low.
- R8: `tx_ready` is high when the block is idle and `start` is high. It is also high during the parity bit of a byte not flagged last, until a byte is taken. A byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high.
- R9: If no byte is taken during the parity bit of a byte not flagged last, that byte's odd parity stands and the frame ends as in R7.
- R10: A `start` pulse while `busy` is high is ignored, including its speed select. A `start` with `tx_valid` low does not begin a frame.
- R11: While `carrier_ce` is low, the bit timing and the `pause` output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_ce | input | 1 | High for one clock per carrier cycle |
| start | input | 1 | Begins a frame when idle and a byte is valid |
| speed_sel | input | 2 | 0: 106, 1: 212, 2/3: 424 kbit/s; latched at start |
| tx_data | input | DATA_W (8) | Payload byte |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_last | input | 1 | The presented byte is the frame's final byte |
| tx_ready | output | 1 | The block takes the byte on this edge if valid |
| pause | output | 1 | Carrier off (modulation pause) |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse after the frame's silent period |

## Verification
The bench compares every carrier cycle of `pause` against a waveform built from the bit rules, so a parity sense flipped at one speed, an LSB-last order or a missed zero-after-one exception appears as a misplaced or missing pause. A frame whose final byte arrives without the last flag checks that the underrun path keeps odd parity and still closes the frame, rather than hanging or turning the parity even. A `start` issued mid-frame with another speed must leave the waveform untouched, and a long stretch with the carrier enable low must freeze an early pause, so a timer that counts raw clocks would produce a short frame.

// File: rtl/pcd_tx_pkg.sv
package pcd_tx_pkg;

   typedef enum logic [1:0] {
      CODE_NONE,
      CODE_EARLY,
      CODE_MID
   } miller_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOF,
      ST_DATA,
      ST_PAR,
      ST_EOF,
      ST_QUIET
   } frm_state_e;

   // Pause placement for one logical bit given the bit before it
   function automatic miller_code_e miller_code(input logic bit_val, input logic prev_bit);
      if (bit_val)
         return CODE_MID;
      else if (prev_bit)
         return CODE_NONE;
      else
         return CODE_EARLY;
   endfunction

endpackage

// File: rtl/pcd_bit_timer.sv
module pcd_bit_timer
   import pcd_tx_pkg::*;
#(
   parameter int BASE_CYC = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ce,
   input  logic         run,
   input  logic [1:0]   speed,
   input  miller_code_e code,
   output logic         bit_end,
   output logic         pause
);
   localparam int CW = $clog2(BASE_CYC);

   if (BASE_CYC < 16 || (BASE_CYC & (BASE_CYC - 1)) != 0) begin : g_bad_base
      $error("BASE_CYC must be a power of two of at least 16");
   end

   logic [CW-1:0] cnt;
   logic [1:0]    spd;
   logic [CW:0]   len, half, quarter, cnt_x;
   logic          in_win;

   always_comb begin
      spd     = (speed == 2'd3) ? 2'd2 : speed;
      len     = (CW + 1)'(BASE_CYC) >> spd;
      half    = len >> 1;
      quarter = len >> 2;
      cnt_x   = {1'b0, cnt};
   end

   assign bit_end = run && ce && (cnt_x == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run && ce)
         cnt <= bit_end ? '0 : cnt + 1'b1;
   end

   always_comb begin
      unique case (code)
         CODE_EARLY: in_win = cnt_x < quarter;
         CODE_MID:   in_win = (cnt_x >= half) && (cnt_x < half + quarter);
         default:    in_win = 1'b0;
      endcase
   end

   assign pause = run && in_win;

endmodule

// File: rtl/pcd_frame_seq.sv
module pcd_frame_seq
   import pcd_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        speed_in,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              byte_valid,
   input  logic              byte_last,
   output logic              byte_ready,
   input  logic              bit_end,
   output logic              run,
   output logic [1:0]        speed_q,
   output miller_code_e      code,
   output logic              done
);
   localparam int IW = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   frm_state_e        st;
   logic [DATA_W-1:0] cur, nxt, nbyte;
   logic              cur_last, nxt_last, have_next, nlast, cur_bit;
   logic [IW-1:0]     idx, nxt_idx;
   logic              is_idle, want_next, go, take, hi, par_bit, more, sof_bit;

   always_comb begin
      is_idle   = (st == ST_IDLE);
      want_next = (st == ST_PAR) && !cur_last && !have_next;
      go        = is_idle && start && byte_valid;
      take      = want_next && byte_valid;
      hi        = (speed_q != 2'd0);
      par_bit   = (hi && cur_last) ? ^cur : ~^cur;
      more      = !cur_last && (have_next || take);
      nbyte     = have_next ? nxt : byte_in;
      nlast     = have_next ? nxt_last : byte_last;
      sof_bit   = (speed_in == 2'd0);
      nxt_idx   = idx + 1'b1;
   end

   assign byte_ready = (is_idle && start) || want_next;
   assign run        = !is_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         speed_q   <= 2'd0;
         cur       <= '0;
         cur_last  <= 1'b0;
         nxt       <= '0;
         nxt_last  <= 1'b0;
         have_next <= 1'b0;
         idx       <= '0;
         cur_bit   <= 1'b0;
         code      <= CODE_NONE;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (take && !bit_end) begin
            nxt       <= byte_in;
            nxt_last  <= byte_last;
            have_next <= 1'b1;
         end
         if (go) begin
            st        <= ST_SOF;
            speed_q   <= speed_in;
            cur       <= byte_in;
            cur_last  <= byte_last;
            have_next <= 1'b0;
            cur_bit   <= sof_bit;
            code      <= miller_code(sof_bit, 1'b0);
         end else if (bit_end) begin
            unique case (st)
               ST_SOF: begin
                  st      <= ST_DATA;
                  idx     <= '0;
                  cur_bit <= cur[0];
                  code    <= miller_code(cur[0], cur_bit);
               end
               ST_DATA: begin
                  if (idx == IW'(DATA_W - 1)) begin
                     st      <= ST_PAR;
                     cur_bit <= par_bit;
                     code    <= miller_code(par_bit, cur_bit);
                  end else begin
                     idx     <= nxt_idx;
                     cur_bit <= cur[nxt_idx];
                     code    <= miller_code(cur[nxt_idx], cur_bit);
                  end
               end
               ST_PAR: begin
                  if (more) begin
                     st        <= ST_DATA;
                     idx       <= '0;
                     cur       <= nbyte;
                     cur_last  <= nlast;
                     have_next <= 1'b0;
                     cur_bit   <= nbyte[0];
                     code      <= miller_code(nbyte[0], cur_bit);
                  end else begin
                     st      <= ST_EOF;
                     cur_bit <= 1'b0;
                     code    <= miller_code(1'b0, cur_bit);
                  end
               end
               ST_EOF: begin
                  st   <= ST_QUIET;
                  code <= CODE_NONE;
               end
               ST_QUIET: begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                  code <= CODE_NONE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/pcd_tx_framer.sv
module pcd_tx_framer
   import pcd_tx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BASE_CYC = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              carrier_ce,
   input  logic              start,
   input  logic [1:0]        speed_sel,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   input  logic              tx_last,
   output logic              tx_ready,
   output logic              pause,
   output logic              busy,
   output logic              done
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic         bit_end, run;
   logic [1:0]   speed_q;
   miller_code_e code;

   pcd_frame_seq #(.DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .speed_in   (speed_sel),
      .byte_in    (tx_data),
      .byte_valid (tx_valid),
      .byte_last  (tx_last),
      .byte_ready (tx_ready),
      .bit_end    (bit_end),
      .run        (run),
      .speed_q    (speed_q),
      .code       (code),
      .done       (done)
   );

   pcd_bit_timer #(.BASE_CYC(BASE_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce      (carrier_ce),
      .run     (run),
      .speed   (speed_q),
      .code    (code),
      .bit_end (bit_end),
      .pause   (pause)
   );

   assign busy = run;

endmodule

// File: rtl/pcd_tx_framer_chk.sv
module pcd_tx_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic carrier_ce,
   input logic start,
   input logic tx_valid,
   input logic tx_ready,
   input logic pause,
   input logic busy,
   input logic done
);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_pause_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pause |-> busy);

   p_ready_when_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (busy || start));

   p_begin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start && tx_valid));

   p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !carrier_ce) |=> $stable(pause));

endmodule

bind pcd_tx_framer pcd_tx_framer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .carrier_ce (carrier_ce),
   .start      (start),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .pause      (pause),
   .busy       (busy),
   .done       (done)
);

// File: tb/pcd_tx_framer_test.sv
`timescale 1ns/1ps
module pcd_tx_framer_test;
   logic       clk = 1'b0, rst_n = 1'b0, carrier_ce = 1'b0, start = 1'b0;
   logic [1:0] speed_sel = 2'd0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0, tx_last = 1'b0;
   wire        tx_ready, pause, busy, done;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   pcd_tx_framer uut (
      .clk(clk), .rst_n(rst_n), .carrier_ce(carrier_ce), .start(start),
      .speed_sel(speed_sel), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .tx_ready(tx_ready), .pause(pause), .busy(busy),
      .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // {speed[47:46], nbytes[45:43], no_last[42], poke[41], pad[40:32], bytes[31:0] (byte 0 lowest)}
   localparam logic [47:0] VEC [7] = '{
      {2'd0, 3'd1, 1'b0, 1'b0, 9'd0, 32'h000000A5},
      {2'd0, 3'd2, 1'b0, 1'b0, 9'd0, 32'h0000FF00},
      {2'd1, 3'd1, 1'b0, 1'b0, 9'd0, 32'h00000026},
      {2'd1, 3'd3, 1'b0, 1'b0, 9'd0, 32'h003C8001},
      {2'd2, 3'd2, 1'b0, 1'b1, 9'd0, 32'h00002093},
      {2'd1, 3'd2, 1'b1, 1'b0, 9'd0, 32'h0000AA55},
      {2'd2, 3'd4, 1'b0, 1'b0, 9'd0, 32'h78563412}
   };

   logic exp_p [0:8191];
   int   exp_len;

   task automatic build(input logic [1:0] spd, input int n, input bit no_last,
                        input logic [31:0] bytes);
      int   len;
      int   nbits;
      logic bl [0:63];
      logic prev;
      len = 128 >> spd;
      bl[0] = (spd == 2'd0);
      nbits = 1;
      for (int j = 0; j < n; j++) begin
         logic [7:0] b;
         b = bytes[8*j +: 8];
         for (int k = 0; k < 8; k++) begin
            bl[nbits] = b[k];
            nbits = nbits + 1;
         end
         bl[nbits] = (spd != 2'd0 && j == n - 1 && !no_last) ? ^b : ~^b;
         nbits = nbits + 1;
      end
      bl[nbits] = 1'b0;
      nbits = nbits + 1;
      prev = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         for (int c = 0; c < len; c++) begin
            if (bl[i])
               exp_p[i*len + c] = (c >= len/2) && (c < 3*len/4);
            else
               exp_p[i*len + c] = !prev && (c < len/4);
         end
         prev = bl[i];
      end
      for (int c = 0; c < len; c++) exp_p[nbits*len + c] = 1'b0;
      exp_len = (nbits + 1) * len;
   endtask

   task automatic run_vec(input logic [47:0] v);
      logic [1:0]  spd;
      int          n, idx, bad, first_bad, notbusy;
      bit          no_last, poke, took;
      logic [31:0] bytes;
      string       rq;
      spd     = v[47:46];
      n       = int'(v[45:43]);
      no_last = v[42];
      poke    = v[41];
      bytes   = v[31:0];
      rq = (spd == 2'd0) ? "R2 R3 R5 R6" : "R2 R4 R5 R6";
      if (no_last) rq = "R9";
      if (poke) rq = "R10";
      build(spd, n, no_last, bytes);
      @(negedge clk);
      start = 1'b1; speed_sel = spd; tx_valid = 1'b1;
      tx_data = bytes[7:0]; tx_last = (n == 1) && !no_last;
      @(posedge clk); #1;
      start = 1'b0;
      idx = 1;
      if (idx < n) begin
         tx_data = bytes[8*idx +: 8]; tx_last = (idx == n - 1) && !no_last;
      end else tx_valid = 1'b0;
      bad = 0; first_bad = -1; notbusy = 0;
      for (int cyc = 0; cyc < exp_len; cyc++) begin
         @(negedge clk);
         if (pause !== exp_p[cyc]) begin
            if (bad == 0) first_bad = cyc;
            bad++;
         end
         if (busy !== 1'b1) notbusy++;
         took = tx_valid && tx_ready;
         @(posedge clk); #1;
         if (took) begin
            idx++;
            if (idx < n) begin
               tx_data = bytes[8*idx +: 8]; tx_last = (idx == n - 1) && !no_last;
            end else tx_valid = 1'b0;
         end
         start = poke && (cyc == exp_len / 2);
         if (poke) speed_sel = ~spd;
      end
      start = 1'b0;
      check(bad == 0, rq, "pause waveform mismatches (first bad cycle in actual)",
            first_bad, -1);
      check(notbusy == 0, "R2", "cycles not busy inside frame", notbusy, 0);
      check(idx == n, "R8", "bytes taken over handshake", idx, n);
      @(negedge clk);
      check(done === 1'b1 && busy === 1'b0, "R7", "done high and busy low after silent bit",
            {30'd0, done, busy}, 2);
      @(negedge clk);
      check(done === 1'b0, "R7", "done width one clock", int'(done), 0);
   endtask

   initial begin
      #(200000 * 4);
      errors++; checks++;
      $display("FAIL R7 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int c;
      int frozen_bad;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pause === 1'b0 && busy === 1'b0 && done === 1'b0 && tx_ready === 1'b0,
            "R1", "outputs during reset", {28'd0, pause, busy, done, tx_ready}, 0);
      rst_n = 1'b1; carrier_ce = 1'b1;
      @(negedge clk);
      check(pause === 1'b0 && busy === 1'b0 && done === 1'b0 && tx_ready === 1'b0,
            "R1", "outputs after reset", {28'd0, pause, busy, done, tx_ready}, 0);

      // R10: start without a valid byte
      start = 1'b1; tx_valid = 1'b0;
      @(posedge clk); #1; start = 1'b0;
      @(negedge clk);
      check(busy === 1'b0, "R10", "busy after start with no valid byte", int'(busy), 0);

      for (int v = 0; v < 7; v++) run_vec(VEC[v]);

      // R11: carrier enable held low freezes the opening early pause at 212 kbit/s
      @(negedge clk);
      carrier_ce = 1'b0;
      start = 1'b1; speed_sel = 2'd1; tx_valid = 1'b1; tx_data = 8'h5A; tx_last = 1'b1;
      @(posedge clk); #1; start = 1'b0; tx_valid = 1'b0;
      frozen_bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (pause !== 1'b1 || busy !== 1'b1) frozen_bad++;
      end
      check(frozen_bad == 0, "R11", "cycles where frozen pause moved", frozen_bad, 0);
      @(posedge clk); #1; carrier_ce = 1'b1;
      c = 0;
      while (c < 2000) begin
         @(negedge clk);
         c++;
         if (done === 1'b1) break;
      end
      check(c == 769, "R11", "clock of done after enable resumed", c, 769);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule